// File: doc/BRIEF.md
# Interrupt Entry and Return Sequencer

This block is the interrupt sequencing unit beside the datapath of a small 8-bit processor with a 16-bit program counter. It holds a latch for each interrupt source. When the processor signals the end of an instruction, the global enable is set and a latch is pending, the block accepts the lowest-numbered pending source. It then runs a fixed internal call in place of the next fetch. It drops the global enable, saves the return address on a byte-wide stack through a memory port addressed by its own 8-bit stack pointer, and hands the processor the vector of the accepted source.

A return command runs the reverse walk. The high byte comes off the stack first and the low byte second, the restored address goes back to the processor, and the global enable is set again. Each stack access takes exactly one clock and the memory returns read data in the same cycle. The memory port therefore has no handshake and no back-pressure: the sequencer owns the port for the whole entry or return and the memory must always be able to accept the access.

Top module: `irq_sequencer`

## Requirements
- R1: After reset the global enable `ea` is 0, no source is pending, `busy` is 0, `pc_load`, `mem_we` and `mem_re` are 0, and `sp` equals the parameter `SP_INIT` (default 8'hFD).
- R2: A pulse on `irq_req[i]` sets latch i, which stays set until it is accepted or `irq_clr[i]` clears it. When a request and a clear for the same source fall in the same cycle, the request wins.
- R3: A source is accepted only in a cycle where `instr_end` is 1, `ea` is 1, `busy` is 0 and at least one latch is set. A strobe on `instr_end` while `ea` is 0 or while `busy` is 1 starts nothing.
- R4: Among pending sources the lowest index is accepted. Only that source's latch is cleared, and the other latches stay pending.
- R5: `ea` reads 0 from the cycle after acceptance. In that cycle the block writes the low byte of `pc_in` (as sampled at acceptance) to address SP+1. In the next cycle it writes the high byte to SP+2. `sp` then holds the old value plus 2.
- R6: In the third cycle after acceptance `pc_load` is 1 for exactly one cycle, with `pc_out` = 16'h0003 + 8*index of the accepted source.
- R7: `busy` is 1 in exactly the three cycles after an acceptance or after a return strobe, and 0 otherwise.
- R8: In the cycle after `reti` (sampled while not busy), the block reads the high byte at address SP. In the next cycle it reads the low byte at SP-1. In the third cycle `pc_load` pulses with `pc_out` = {high, low}. `ea` reads 1 from the cycle after that, and `sp` has dropped by 2.
- R9: The stack pointer wraps modulo 256 in both directions.
- R10: While `busy` is 1, `ea_set` and `ea_clr` have no effect. While idle, `ea_clr` wins over `ea_set`.
- R11: When `reti` and an acceptable `instr_end` arrive in the same cycle, the return runs and all pending latches are kept.
- R12: `mem_we` and `mem_re` are never 1 together, and both are 0 whenever `busy` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| irq_req | input | N_SRC | Request pulses, one per source |
| irq_clr | input | N_SRC | Explicit latch clear, one per source |
| ea_set | input | 1 | Set global enable (idle only) |
| ea_clr | input | 1 | Clear global enable (idle only) |
| instr_end | input | 1 | Last cycle of the current instruction |
| reti | input | 1 | Return-from-interrupt strobe |
| pc_in | input | 16 | Address to resume at after the current instruction |
| ea | output | 1 | Global interrupt enable |
| busy | output | 1 | Entry or return sequence in progress |
| pc_load | output | 1 | One-cycle strobe: load `pc_out` into the PC |
| pc_out | output | 16 | Vector or restored return address |
| sp | output | 8 | Stack pointer |
| mem_we | output | 1 | Stack write |
| mem_re | output | 1 | Stack read |
| mem_addr | output | 8 | Stack address |
| mem_wdata | output | 8 | Stack write data |
| mem_rdata | input | 8 | Stack read data, same cycle |

## Verification
The hardest case to reach from the ports is a return that arrives in the same cycle as an acceptable instruction end while other sources stay latched. The bench builds this case directly: it nests one entry inside a service routine so that a return is legal, re-raises a request, and then strobes both inputs together. It proves the latches survived by taking the pending source once the return has finished. Stack-pointer wrap comes from the reset value sitting just below 256, so the second nested entry writes at addresses 0 and 1. The random phase then mixes requests, clears, enable writes, entries and returns against a bench model of latches, enable and stack.

// File: rtl/irqs_pkg.sv
package irqs_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PUSH_LO,
    ST_PUSH_HI,
    ST_VECTOR,
    ST_POP_HI,
    ST_POP_LO,
    ST_RESUME
  } seq_state_t;
endpackage

// File: rtl/irqs_pend_latch.sv
module irqs_pend_latch #(
  parameter int N_SRC = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_SRC-1:0] req,
  input  logic [N_SRC-1:0] clr,
  input  logic [N_SRC-1:0] take,
  output logic [N_SRC-1:0] pend
);
  logic [N_SRC-1:0] pend_q;

  for (genvar g = 0; g < N_SRC; g++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pend_q[g] <= 1'b0;
      else if (req[g]) pend_q[g] <= 1'b1;
      else if (clr[g] || take[g]) pend_q[g] <= 1'b0;
    end
  end

  assign pend = pend_q;

  // R4: a taken source with no fresh request is gone next cycle
  a_r4_take_clears: assert property (@(posedge clk) disable iff (!rst_n)
    ((take & ~req) != '0) |=> ((pend_q & $past(take & ~req)) == '0));
  // R2: bits with neither clear nor take hold their value
  a_r2_latch_holds: assert property (@(posedge clk) disable iff (!rst_n)
    ((clr | take) == '0) |=> ((pend_q & $past(pend_q)) == $past(pend_q)));
endmodule

// File: rtl/irqs_pick.sv
module irqs_pick #(
  parameter int N_SRC = 8,
  localparam int IDXW = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
  input  logic [N_SRC-1:0] pend,
  output logic [N_SRC-1:0] grant,
  output logic [IDXW-1:0]  idx,
  output logic             any
);
  always_comb begin
    grant = '0;
    idx   = '0;
    for (int i = N_SRC - 1; i >= 0; i--) begin
      if (pend[i]) begin
        grant = '0;
        grant[i] = 1'b1;
        idx = IDXW'(i);
      end
    end
    any = |pend;
  end
endmodule

// File: rtl/irqs_seq.sv
module irqs_seq
  import irqs_pkg::*;
#(
  parameter int          IDXW      = 3,
  parameter logic [15:0] VEC_BASE  = 16'h0003,
  parameter logic [15:0] VEC_STEP  = 16'h0008,
  parameter logic [7:0]  SP_INIT   = 8'hFD
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            instr_end,
  input  logic            reti,
  input  logic            ea_set,
  input  logic            ea_clr,
  input  logic            any_pend,
  input  logic [IDXW-1:0] win_idx,
  input  logic [15:0]     pc_in,
  input  logic [7:0]      mem_rdata,
  output logic            accept,
  output logic            ea,
  output logic            busy,
  output logic            pc_load,
  output logic [15:0]     pc_out,
  output logic [7:0]      sp,
  output logic            mem_we,
  output logic            mem_re,
  output logic [7:0]      mem_addr,
  output logic [7:0]      mem_wdata
);
  seq_state_t  state_q, state_d;
  logic [7:0]  sp_q;
  logic        ea_q;
  logic [15:0] ret_q;
  logic [15:0] vec_q;
  logic [7:0]  hi_q, lo_q;
  logic        start_ret;

  assign busy      = (state_q != ST_IDLE);
  assign start_ret = (state_q == ST_IDLE) && reti;
  assign accept    = (state_q == ST_IDLE) && !reti && instr_end && ea_q && any_pend;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: begin
        if (start_ret)   state_d = ST_POP_HI;
        else if (accept) state_d = ST_PUSH_LO;
      end
      ST_PUSH_LO: state_d = ST_PUSH_HI;
      ST_PUSH_HI: state_d = ST_VECTOR;
      ST_VECTOR:  state_d = ST_IDLE;
      ST_POP_HI:  state_d = ST_POP_LO;
      ST_POP_LO:  state_d = ST_RESUME;
      ST_RESUME:  state_d = ST_IDLE;
      default:    state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      sp_q    <= SP_INIT;
      ea_q    <= 1'b0;
      ret_q   <= '0;
      vec_q   <= '0;
      hi_q    <= '0;
      lo_q    <= '0;
    end else begin
      state_q <= state_d;
      unique case (state_q)
        ST_IDLE: begin
          if (accept) begin
            ea_q  <= 1'b0;
            ret_q <= pc_in;
            vec_q <= VEC_BASE + {{(16-IDXW){1'b0}}, win_idx} * VEC_STEP;
          end else if (!start_ret) begin
            if (ea_clr)      ea_q <= 1'b0;
            else if (ea_set) ea_q <= 1'b1;
          end
        end
        ST_PUSH_LO, ST_PUSH_HI: sp_q <= sp_q + 8'd1;
        ST_POP_HI: begin
          hi_q <= mem_rdata;
          sp_q <= sp_q - 8'd1;
        end
        ST_POP_LO: begin
          lo_q <= mem_rdata;
          sp_q <= sp_q - 8'd1;
        end
        ST_RESUME: ea_q <= 1'b1;
        default: ;
      endcase
    end
  end

  always_comb begin
    mem_we    = 1'b0;
    mem_re    = 1'b0;
    mem_addr  = sp_q;
    mem_wdata = '0;
    pc_load   = 1'b0;
    pc_out    = vec_q;
    unique case (state_q)
      ST_PUSH_LO: begin
        mem_we = 1'b1; mem_addr = sp_q + 8'd1; mem_wdata = ret_q[7:0];
      end
      ST_PUSH_HI: begin
        mem_we = 1'b1; mem_addr = sp_q + 8'd1; mem_wdata = ret_q[15:8];
      end
      ST_VECTOR: pc_load = 1'b1;
      ST_POP_HI, ST_POP_LO: mem_re = 1'b1;
      ST_RESUME: begin
        pc_load = 1'b1; pc_out = {hi_q, lo_q};
      end
      default: ;
    endcase
  end

  assign ea = ea_q;
  assign sp = sp_q;

  // R12: one stack access at a time, none while idle
  a_r12_one_access: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_we && mem_re) && ((mem_we || mem_re) -> busy));
  // R5: enable is down while the return address is being saved
  a_r5_ea_low_in_entry: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> !ea_q);
  // R5: second push goes one above the first
  a_r5_push_order: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && $past(mem_we)) |-> (mem_addr == $past(mem_addr) + 8'd1));
  // R8: second pop goes one below the first
  a_r8_pop_order: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_re && $past(mem_re)) |-> (mem_addr == $past(mem_addr) - 8'd1));
  // R6: load strobe lasts one cycle
  a_r6_load_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    pc_load |=> !pc_load);
  // R10: software enable writes do not move ea during a sequence
  a_r10_ea_locked: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !pc_load) |=> $stable(ea_q));
endmodule

// File: rtl/irq_sequencer.sv
module irq_sequencer #(
  parameter int          N_SRC    = 8,
  parameter logic [15:0] VEC_BASE = 16'h0003,
  parameter logic [15:0] VEC_STEP = 16'h0008,
  parameter logic [7:0]  SP_INIT  = 8'hFD
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_SRC-1:0] irq_req,
  input  logic [N_SRC-1:0] irq_clr,
  input  logic             ea_set,
  input  logic             ea_clr,
  input  logic             instr_end,
  input  logic             reti,
  input  logic [15:0]      pc_in,
  output logic             ea,
  output logic             busy,
  output logic             pc_load,
  output logic [15:0]      pc_out,
  output logic [7:0]       sp,
  output logic             mem_we,
  output logic             mem_re,
  output logic [7:0]       mem_addr,
  output logic [7:0]       mem_wdata,
  input  logic [7:0]       mem_rdata
);
  localparam int IDXW = (N_SRC > 1) ? $clog2(N_SRC) : 1;

  logic [N_SRC-1:0] pend, grant, take;
  logic [IDXW-1:0]  win_idx;
  logic             any_pend, accept;

  assign take = accept ? grant : '0;

  irqs_pend_latch #(.N_SRC(N_SRC)) u_latch (
    .clk(clk), .rst_n(rst_n), .req(irq_req), .clr(irq_clr),
    .take(take), .pend(pend)
  );

  irqs_pick #(.N_SRC(N_SRC)) u_pick (
    .pend(pend), .grant(grant), .idx(win_idx), .any(any_pend)
  );

  irqs_seq #(
    .IDXW(IDXW), .VEC_BASE(VEC_BASE), .VEC_STEP(VEC_STEP), .SP_INIT(SP_INIT)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .instr_end(instr_end), .reti(reti),
    .ea_set(ea_set), .ea_clr(ea_clr), .any_pend(any_pend), .win_idx(win_idx),
    .pc_in(pc_in), .mem_rdata(mem_rdata), .accept(accept), .ea(ea),
    .busy(busy), .pc_load(pc_load), .pc_out(pc_out), .sp(sp),
    .mem_we(mem_we), .mem_re(mem_re), .mem_addr(mem_addr), .mem_wdata(mem_wdata)
  );

  // R4: the winner is a single pending source
  a_r4_grant_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant) && ((grant & ~pend) == '0));
  // R3: nothing is taken while busy or disabled
  a_r3_no_take_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (busy || !ea) |-> (take == '0));
endmodule

// File: tb/irq_sequencer_bench.sv
module irq_sequencer_bench;
  localparam int N = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [N-1:0] irq_req = '0, irq_clr = '0;
  logic ea_set = 0, ea_clr = 0, instr_end = 0, reti = 0;
  logic [15:0] pc_in = '0;
  logic ea, busy, pc_load, mem_we, mem_re;
  logic [15:0] pc_out;
  logic [7:0] sp, mem_addr, mem_wdata, mem_rdata;
  logic [7:0] ram [256];

  int total = 0, bad = 0;
  logic [N-1:0] pend_m = '0;
  logic ea_m = 0;
  logic [7:0] sp_m = 8'hFD;
  logic [15:0] saved [64];
  int depth = 0;

  always #2.5 clk = ~clk;

  irq_sequencer u_irq_sequencer (
    .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .irq_clr(irq_clr),
    .ea_set(ea_set), .ea_clr(ea_clr), .instr_end(instr_end), .reti(reti),
    .pc_in(pc_in), .ea(ea), .busy(busy), .pc_load(pc_load), .pc_out(pc_out),
    .sp(sp), .mem_we(mem_we), .mem_re(mem_re), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
  );

  assign mem_rdata = ram[mem_addr];
  always @(posedge clk) if (mem_we) ram[mem_addr] <= mem_wdata;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] vec_of(input logic [N-1:0] p);
    for (int i = 0; i < N; i++) if (p[i]) return 16'h0003 + 16'(8 * i);
    return 16'h0;
  endfunction

  function automatic logic [N-1:0] low_bit(input logic [N-1:0] p);
    return p & (~p + 1'b1);
  endfunction

  task automatic cyc; @(negedge clk); endtask

  task automatic raise(input logic [N-1:0] r, input logic [N-1:0] c);
    irq_req = r; irq_clr = c; cyc();
    irq_req = '0; irq_clr = '0;
    pend_m = (pend_m & ~c) | r;
  endtask

  task automatic set_ea(input logic s, input logic c);
    ea_set = s; ea_clr = c; cyc();
    ea_set = 0; ea_clr = 0;
    if (c) ea_m = 0; else if (s) ea_m = 1;
    chk("R10 ea write", ea, ea_m);
  endtask

  // Full entry; assumes acceptance is expected
  task automatic entry(input logic [15:0] pc, input logic poke);
    logic [15:0] v;
    v = vec_of(pend_m);
    pc_in = pc; instr_end = 1; cyc();
    instr_end = 0;
    pend_m = pend_m & ~low_bit(pend_m);
    chk("R5 we lo", mem_we, 1); chk("R5 addr lo", mem_addr, 8'(sp_m + 8'd1));
    chk("R5 data lo", mem_wdata, pc[7:0]); chk("R5 ea low", ea, 0);
    chk("R7 busy e1", busy, 1);
    if (poke) begin ea_set = 1; instr_end = 1; end
    cyc();
    ea_set = 0; instr_end = 0;
    chk("R5 we hi", mem_we, 1); chk("R9 R5 addr hi", mem_addr, 8'(sp_m + 8'd2));
    chk("R5 data hi", mem_wdata, pc[15:8]);
    cyc();
    chk("R6 load", pc_load, 1); chk("R6 vector", pc_out, v);
    chk("R12 no mem", {mem_we, mem_re}, 0);
    cyc();
    chk("R7 idle", busy, 0); chk("R6 pulse", pc_load, 0);
    sp_m = sp_m + 8'd2; ea_m = 0;
    chk("R5 sp", sp, sp_m); chk("R10 ea", ea, 0);
    saved[depth] = pc; depth++;
  endtask

  task automatic ret_seq(input logic with_end);
    logic [15:0] r;
    depth--; r = saved[depth];
    reti = 1; instr_end = with_end; cyc();
    reti = 0; instr_end = 0;
    chk("R8 re hi", mem_re, 1); chk("R8 addr hi", mem_addr, sp_m);
    chk("R12 no we", mem_we, 0); chk("R7 busy r", busy, 1);
    cyc();
    chk("R8 re lo", mem_re, 1); chk("R9 R8 addr lo", mem_addr, 8'(sp_m - 8'd1));
    cyc();
    chk("R8 load", pc_load, 1); chk("R8 pc", pc_out, r);
    cyc();
    sp_m = sp_m - 8'd2; ea_m = 1;
    chk("R8 ea", ea, 1); chk("R8 sp", sp, sp_m); chk("R7 done", busy, 0);
  endtask

  task automatic try_none;
    instr_end = 1; pc_in = 16'hDEAD; cyc();
    instr_end = 0;
    chk("R3 no accept busy", busy, 0); chk("R3 no write", mem_we, 0);
    cyc();
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd20250));
    for (int i = 0; i < 256; i++) ram[i] = 8'h00;
    repeat (3) cyc();
    chk("R1 ea", ea, 0); chk("R1 busy", busy, 0); chk("R1 sp", sp, 8'hFD);
    chk("R1 mem", {mem_we, mem_re, pc_load}, 0);
    rst_n = 1; cyc();

    // R3: pending but disabled -> no acceptance
    raise(8'b0010_0100, '0);
    try_none();
    // R2: clear removes bit 2; bit 5 remains
    raise('0, 8'b0000_0100);
    set_ea(1, 0);
    // R4: lowest remaining is 5; add 6 too
    raise(8'b0100_0000, '0);
    entry(16'h1234, 1);          // R10/R3 poke during busy
    try_none();                  // R3: ea is 0 now
    // R2: request wins over same-cycle clear
    raise(8'b0000_0010, 8'b0000_0010);
    set_ea(0, 1); set_ea(1, 1);  // R10: clear wins
    set_ea(1, 0);
    entry(16'hA55A, 0);          // R9: nested entry writes 00 and 01
    // R11: reti together with an acceptable instr_end
    set_ea(1, 0);
    ret_seq(1);
    chk("R11 kept", busy, 0);
    entry(16'h0F0F, 0);          // takes source 6 kept across the return
    ret_seq(0);
    ret_seq(0);

    // Random phase
    for (int k = 0; k < 400; k++) begin
      int op;
      op = $urandom_range(0, 5);
      case (op)
        0: raise(N'($urandom), ($urandom_range(0, 3) == 0) ? N'($urandom) : '0);
        1: set_ea(1, 0);
        2: set_ea(0, 1);
        3, 4: begin
          if (ea_m && pend_m != '0 && depth < 60) entry(16'($urandom), 0);
          else if (!(ea_m && pend_m != '0)) try_none();
        end
        default: if (depth > 0) ret_seq(0);
      endcase
    end
    while (depth > 0) ret_seq(0);
    cyc();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule